// File: doc/BRIEF.md
# TDM Audio Serial Transmitter

This block drives one serial audio data line in time-division-multiplexed frames. It runs entirely in the bit-clock domain. Sample words arrive over a valid/ready interface into a one-word holding register. Each slot of the outgoing frame takes one word and serializes it. The serialization follows a format set by static inputs: the number of slots, the slot width, the data word width, the delay from frame sync to the first data bit, the bit order, and whether the word sits at the start or the end of its slot.

Two framing modes exist. In periodic mode the block makes its own one-cycle frame sync and sends frames back to back for as long as the enable is held. In burst mode each pulse on an external sync input starts a single slot, and the line stays quiet between pulses. The format inputs are captured when a frame starts, so they can be changed at any time without corrupting a frame already on the line. If a slot begins while the holding register is empty, the slot is sent as zeros and a sticky underrun flag is raised.

Top module: `tdm_tx`

## Requirements
- R1: While rst_ni is low, sd_o and fs_o are 0, s_ready_o is 1 and underrun_o is 0.
- R2: In periodic mode (burst_i=0), fs_o is high for exactly one cycle at the first bit of each frame. The frame period is slots_i × slot width cycles, and slots_i is valid from 2 to 32.
- R3: The slot width is 8 + 4·slot_wsel_i bits for slot_wsel_i 0..6. The data word width is 8 + 4·word_wsel_i bits, limited to the slot width, and is taken from the low bits of s_data_i.
- R4: Frame bit 0 appears on sd_o delay_i cycles (0, 1 or 2) after the cycle in which the frame starts (the fs_o cycle in periodic mode). The whole bit stream is shifted by the same amount.
- R5: With lsb_first_i=0 the word is sent most significant bit first. With lsb_first_i=1 it is sent least significant bit first.
- R6: With right_align_i=0 the word fills the first bits of its slot. With right_align_i=1 it fills the last bits. All other slot bits are 0.
- R7: A slot that begins while no word is held is sent as all zeros and sets underrun_o. The flag stays set until clr_underrun_i is sampled high.
- R8: In burst mode (burst_i=1), an ext_fs_i high sampled at a clock edge starts exactly one slot in the next cycle. fs_o stays 0, and sd_o is 0 outside the slot.
- R9: Format inputs are captured only at a frame start. A change made during a frame takes effect from the next frame.
- R10: The first periodic frame starts in the cycle after en_i is first sampled high. When en_i is sampled low at the end of a frame, no further frame starts and sd_o returns to 0.
- R11: s_ready_o is 1 exactly when the holding register is empty. Words are transmitted one per slot in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; all outputs change after its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transmitter enable, sampled at frame boundaries |
| burst_i | input | 1 | 1 = burst mode with external sync, 0 = periodic mode |
| ext_fs_i | input | 1 | External sync that starts a burst slot |
| slots_i | input | 6 | Slots per periodic frame (2..32) |
| slot_wsel_i | input | 3 | Slot width select, width = 8 + 4·code |
| word_wsel_i | input | 3 | Data word width select, width = 8 + 4·code |
| delay_i | input | 2 | Frame-sync-to-data delay in bit clocks (0..2) |
| lsb_first_i | input | 1 | 1 = least significant bit first |
| right_align_i | input | 1 | 1 = word at the end of the slot |
| s_data_i | input | 32 | Sample word |
| s_valid_i | input | 1 | Sample word valid |
| s_ready_o | output | 1 | Holding register empty |
| clr_underrun_i | input | 1 | Clears the underrun flag |
| sd_o | output | 1 | Serial data |
| fs_o | output | 1 | Generated frame sync (periodic mode) |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
A wrong slot or bit counter moves fs_o off its frame period, and the fault is visible at the next expected sync pulse, at most one frame later. A wrong bit index, offset or delay setting corrupts sd_o within the first slot of the affected frame. A stale or early format capture shows up as a whole frame sent in the wrong order or alignment. A dropped or duplicated word in the holding register shifts every later slot by one word, so the comparison against the acceptance order fails at the next slot, and the underrun flag rises one slot early or late.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int DATA_W   = 32;
  localparam int IDX_W    = 6;
  localparam int SLOT_MIN = 2;
  localparam int SLOT_MAX = 32;
  localparam int WSEL_MAX = 6;

  typedef struct packed {
    logic             burst;
    logic [IDX_W-1:0] slots;
    logic [IDX_W-1:0] slot_w;
    logic [IDX_W-1:0] word_w;
    logic [1:0]       dly;
    logic             lsb_first;
    logic             r_align;
  } cfg_t;

  function automatic cfg_t decode_cfg(logic [IDX_W-1:0] slots, logic [2:0] wsel,
                                      logic [2:0] nsel, logic [1:0] dly,
                                      logic lsb, logic ra, logic burst);
    cfg_t c;
    logic [2:0] ws, ns;
    ws = (wsel > 3'(WSEL_MAX)) ? 3'(WSEL_MAX) : wsel;
    ns = (nsel > ws) ? ws : nsel;
    c.burst     = burst;
    c.slots     = (slots < IDX_W'(SLOT_MIN)) ? IDX_W'(SLOT_MIN) :
                  (slots > IDX_W'(SLOT_MAX)) ? IDX_W'(SLOT_MAX) : slots;
    c.slot_w    = 6'd8 + {1'b0, ws, 2'b00};
    c.word_w    = 6'd8 + {1'b0, ns, 2'b00};
    c.dly       = (dly == 2'd3) ? 2'd2 : dly;
    c.lsb_first = lsb;
    c.r_align   = ra;
    return c;
  endfunction
endpackage

// File: rtl/tdm_tx_seq.sv
module tdm_tx_seq
  import tdm_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ext_fs_i,
  input  cfg_t             live_cfg_i,
  output cfg_t             cfg_o,
  output logic             active_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             slot_load_o,
  output logic             fs_pulse_o
);
  cfg_t             cfg_q;
  logic             active_q;
  logic [IDX_W-1:0] bit_q, slot_q;
  logic             start_ok, slot_end, frame_end, frame_start;

  assign start_ok    = en_i && (!live_cfg_i.burst || ext_fs_i);
  assign slot_end    = active_q && (bit_q == cfg_q.slot_w - 6'd1);
  assign frame_end   = slot_end && (cfg_q.burst || (slot_q == cfg_q.slots - 6'd1));
  assign frame_start = (!active_q || frame_end) && start_ok;
  assign slot_load_o = frame_start || (slot_end && !frame_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      bit_q    <= '0;
      slot_q   <= '0;
      cfg_q    <= '0;
    end else if (!active_q || frame_end) begin
      active_q <= start_ok;
      bit_q    <= '0;
      slot_q   <= '0;
      if (start_ok) cfg_q <= live_cfg_i;
    end else if (slot_end) begin
      bit_q  <= '0;
      slot_q <= slot_q + 6'd1;
    end else begin
      bit_q <= bit_q + 6'd1;
    end
  end

  assign cfg_o      = cfg_q;
  assign active_o   = active_q;
  assign bit_idx_o  = bit_q;
  assign fs_pulse_o = active_q && !cfg_q.burst && (bit_q == '0) && (slot_q == '0);

  assert_cfg_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !frame_start) |=> $stable(cfg_q));
  assert_bit_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (bit_q < cfg_q.slot_w));
  assert_fs_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_pulse_o |=> !fs_pulse_o);
endmodule

// File: rtl/tdm_tx_buf.sv
module tdm_tx_buf
  import tdm_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic              load_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] word_o,
  output logic              underrun_o
);
  logic [DATA_W-1:0] buf_q, word_q;
  logic              buf_vld, und_q, accept;

  assign s_ready_o = !buf_vld;
  assign accept    = s_valid_i && !buf_vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      buf_vld <= 1'b0;
      word_q  <= '0;
      und_q   <= 1'b0;
    end else begin
      if (load_i) word_q <= buf_vld ? buf_q : '0;
      if (load_i && !buf_vld) und_q <= 1'b1;
      else if (clr_i)         und_q <= 1'b0;
      if (accept) begin
        buf_q   <= s_data_i;
        buf_vld <= 1'b1;
      end else if (load_i) begin
        buf_vld <= 1'b0;
      end
    end
  end

  assign word_o     = word_q;
  assign underrun_o = und_q;

  assert_underrun_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (und_q && !clr_i) |=> und_q);
  assert_no_overwrite_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_vld && !load_i) |=> (buf_vld && $stable(buf_q)));
endmodule

// File: rtl/tdm_tx_fmt.sv
module tdm_tx_fmt
  import tdm_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic [DATA_W-1:0] word_i,
  input  cfg_t              cfg_i,
  output logic              sd_o
);
  logic [IDX_W-1:0] off, k, sel;
  logic             in_word, bit_now;
  logic [1:0]       dline;

  always_comb begin
    off     = cfg_i.r_align ? (cfg_i.slot_w - cfg_i.word_w) : '0;
    in_word = (bit_idx_i >= off) && (bit_idx_i < off + cfg_i.word_w);
    k       = bit_idx_i - off;
    sel     = cfg_i.lsb_first ? k : (cfg_i.word_w - 6'd1 - k);
    bit_now = active_i && in_word && !sel[IDX_W-1] && word_i[sel[IDX_W-2:0]];
  end

  // whole stream delayed, so data may spill past the next frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dline <= '0;
    else         dline <= {dline[0], bit_now};
  end

  always_comb begin
    case (cfg_i.dly)
      2'd0:    sd_o = bit_now;
      2'd1:    sd_o = dline[0];
      default: sd_o = dline[1];
    endcase
  end

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !$past(active_i) && !$past(active_i, 2)) |-> !sd_o);
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              burst_i,
  input  logic              ext_fs_i,
  input  logic [IDX_W-1:0]  slots_i,
  input  logic [2:0]        slot_wsel_i,
  input  logic [2:0]        word_wsel_i,
  input  logic [1:0]        delay_i,
  input  logic              lsb_first_i,
  input  logic              right_align_i,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic              clr_underrun_i,
  output logic              sd_o,
  output logic              fs_o,
  output logic              underrun_o
);
  cfg_t              live_cfg, cfg;
  logic              active, slot_load;
  logic [IDX_W-1:0]  bit_idx;
  logic [DATA_W-1:0] word;

  assign live_cfg = decode_cfg(slots_i, slot_wsel_i, word_wsel_i, delay_i,
                               lsb_first_i, right_align_i, burst_i);

  tdm_tx_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .ext_fs_i(ext_fs_i),
    .live_cfg_i(live_cfg), .cfg_o(cfg), .active_o(active),
    .bit_idx_o(bit_idx), .slot_load_o(slot_load), .fs_pulse_o(fs_o)
  );

  tdm_tx_buf u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .s_data_i(s_data_i), .s_valid_i(s_valid_i),
    .s_ready_o(s_ready_o), .load_i(slot_load), .clr_i(clr_underrun_i),
    .word_o(word), .underrun_o(underrun_o)
  );

  tdm_tx_fmt u_fmt (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active), .bit_idx_i(bit_idx),
    .word_i(word), .cfg_i(cfg), .sd_o(sd_o)
  );

  assert_burst_no_fs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_i && $past(burst_i) && !active |=> !fs_o);
endmodule

// File: tb/tdm_tx_tb_top.sv
module tdm_tx_tb_top;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic en_i = 0, burst_i = 0, ext_fs_i = 0, lsb_first_i = 0, right_align_i = 0;
  logic [5:0] slots_i = 6'd2;
  logic [2:0] slot_wsel_i = 0, word_wsel_i = 0;
  logic [1:0] delay_i = 0;
  logic [31:0] s_data_i = 0;
  logic s_valid_i = 0, clr_underrun_i = 0;
  logic s_ready_o, sd_o, fs_o, underrun_o;

  tdm_tx dut_i (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, tx_k = 0, feed_idx = 0;
  bit feed_on = 0, fire_pending = 0;

  // vector: [15:10] slots [9:7] slot wsel [6:4] word wsel [3:2] delay [1] lsb [0] right
  localparam logic [15:0] VEC [8] = '{
    {6'd2,  3'd0, 3'd0, 2'd0, 1'b0, 1'b0},
    {6'd4,  3'd2, 3'd1, 2'd0, 1'b0, 1'b1},
    {6'd3,  3'd6, 3'd4, 2'd1, 1'b1, 1'b0},
    {6'd2,  3'd3, 3'd3, 2'd2, 1'b0, 1'b0},
    {6'd8,  3'd1, 3'd0, 2'd0, 1'b1, 1'b0},
    {6'd32, 3'd0, 3'd0, 2'd1, 1'b0, 1'b0},
    {6'd2,  3'd5, 3'd2, 2'd2, 1'b1, 1'b1},
    {6'd5,  3'd4, 3'd4, 2'd0, 1'b1, 1'b1}
  };

  function automatic logic [31:0] gen(int k);
    return (32'h9E3779B9 * 32'(k + 1)) ^ (32'(k) << 11) ^ 32'h0F0F1234;
  endfunction

  function automatic int sw_of(logic [15:0] v); return 8 + 4 * int'(v[9:7]); endfunction
  function automatic int nw_of(logic [15:0] v);
    int n = (v[6:4] > v[9:7]) ? int'(v[9:7]) : int'(v[6:4]);
    return 8 + 4 * n;
  endfunction

  function automatic logic exp_bit(logic [31:0] w, int j, int wd, int nd, logic lsb, logic ra);
    int off = ra ? wd - nd : 0;
    if (j < off || j >= off + nd) return 1'b0;
    return lsb ? w[j - off] : w[nd - 1 - (j - off)];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] v);
    slots_i = v[15:10]; slot_wsel_i = v[9:7]; word_wsel_i = v[6:4];
    delay_i = v[3:2]; lsb_first_i = v[1]; right_align_i = v[0];
  endtask

  // feeder: consecutive words, index advances on each accepted handshake
  always @(negedge clk_i) begin
    if (fire_pending) feed_idx = feed_idx + 1;
    s_valid_i = feed_on;
    s_data_i  = gen(feed_idx);
    fire_pending = feed_on && s_ready_o;
  end

  // periodic run: frame 0 with va, frame 1 with vb (vb applied at cycle sw, same delay)
  task automatic run_vec(logic [15:0] va, logic [15:0] vb, int sw, string tag);
    int sa = int'(va[15:10]), sb = int'(vb[15:10]);
    int wa = sw_of(va), wb = sw_of(vb), na = nw_of(va), nb = nw_of(vb);
    int la = sa * wa, lb = sb * wb, dly = int'(va[3:2]);
    int fs_err = 0, d_err = 0, first_fs = 0;
    apply(va);
    en_i = 1;
    for (int c = 1; c <= la + lb + dly + 8; c++) begin
      logic e_fs, e_sd;
      int p;
      @(negedge clk_i);
      if (c == sw) apply(vb);
      if (c == la + 2) en_i = 0;
      if (c == 1) first_fs = fs_o;
      e_fs = (c == 1) || (c == la + 1);
      if (fs_o !== e_fs) fs_err++;
      p = c - 1 - dly;
      if (p < 0 || p >= la + lb) e_sd = 1'b0;
      else if (p < la) e_sd = exp_bit(gen(tx_k + p / wa), p % wa, wa, na, va[1], va[0]);
      else e_sd = exp_bit(gen(tx_k + sa + (p - la) / wb), (p - la) % wb, wb, nb, vb[1], vb[0]);
      if (sd_o !== e_sd) d_err++;
    end
    tx_k += sa + sb;
    chk(first_fs == 1, {"R10 first fs cycle ", tag}, first_fs, 1);
    chk(fs_err == 0, {"R2 fs pattern ", tag}, fs_err, 0);
    chk(d_err == 0, {"R3/R4/R5/R6/R11 data ", tag}, d_err, 0);
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(sd_o === 0 && fs_o === 0, "R1 reset outputs", {sd_o, fs_o}, 0);
    chk(s_ready_o === 1, "R1 reset ready", s_ready_o, 1);
    chk(underrun_o === 0, "R1 reset underrun", underrun_o, 0);
    rst_ni = 1;
    feed_on = 1;
    repeat (4) @(negedge clk_i);
    chk(s_ready_o === 0, "R11 ready low when word held", s_ready_o, 0);
    chk(sd_o === 0 && fs_o === 0, "R10 idle while disabled", {sd_o, fs_o}, 0);

    foreach (VEC[i]) run_vec(VEC[i], VEC[i], 0, $sformatf("vec%0d", i));

    // R9: order and alignment changed mid-frame apply from the next frame
    run_vec({6'd2, 3'd2, 3'd1, 2'd1, 1'b0, 1'b0},
            {6'd2, 3'd2, 3'd1, 2'd1, 1'b1, 1'b1}, 16, "R9 mid-frame change");

    // R8 burst mode
    begin
      int err = 0;
      burst_i = 1; apply({6'd5, 3'd2, 3'd2, 2'd1, 1'b0, 1'b0});
      en_i = 1;
      repeat (6) begin
        @(negedge clk_i);
        if (sd_o !== 0 || fs_o !== 0) err++;
      end
      chk(err == 0, "R8 no slot without sync", err, 0);
      for (int b = 0; b < 2; b++) begin
        int fe = 0;
        err = 0;
        ext_fs_i = 1;
        for (int c = 1; c <= 30; c++) begin
          int p;
          logic e;
          @(negedge clk_i);
          ext_fs_i = 0;
          p = c - 2;
          e = (p >= 0 && p < 16) ? exp_bit(gen(tx_k), p, 16, 16, 1'b0, 1'b0) : 1'b0;
          if (sd_o !== e) err++;
          if (fs_o !== 0) fe++;
        end
        tx_k++;
        chk(err == 0, $sformatf("R8 burst slot %0d data", b), err, 0);
        chk(fe == 0, $sformatf("R8 burst %0d fs_o low", b), fe, 0);
      end
      en_i = 0; burst_i = 0;
      repeat (4) @(negedge clk_i);
    end

    // R7 underrun: feed stopped, one held word covers slot 0 only
    begin
      int err = 0, uerr = 0;
      feed_on = 0;
      repeat (4) @(negedge clk_i);
      apply({6'd2, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0});
      en_i = 1;
      for (int c = 1; c <= 30; c++) begin
        logic e;
        @(negedge clk_i);
        if (c == 2) en_i = 0;
        e = (c <= 8) ? exp_bit(gen(tx_k), c - 1, 8, 8, 1'b0, 1'b0) : 1'b0;
        if (sd_o !== e) err++;
        if (underrun_o !== (c >= 9)) uerr++;
      end
      chk(err == 0, "R7 underrun slot zeros", err, 0);
      chk(uerr == 0, "R7 underrun flag timing and stickiness", uerr, 0);
      clr_underrun_i = 1;
      @(negedge clk_i);
      clr_underrun_i = 0;
      chk(underrun_o === 0, "R7 flag cleared", underrun_o, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule